// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block watches a bank of general-purpose input pins (eight by default) and turns activity on them into interrupt requests. Every pin is first passed through a two-stage synchronizer. Each pin then has its own detector. In edge mode the detector catches rising edges, falling edges, or both. In level mode it reports the pin while the pin sits at a chosen value, high or low.

Software sets up the detectors and reads results through a small register port. Writes are synchronous and reads are combinational. Edge events are held in a raw status bit until software writes a 1 to that bit of the clear register. Level status follows the synchronized pin and is never held. A per-pin mask decides which raw status bits reach the masked status. The single interrupt output is the OR of all masked status bits.

Top module: `gpio_irq_detect`

Register addresses used by the bench, one bit per pin, bit i belonging to pin i:

| Address | Name | Access |
|---|---|---|
| 0 | sense | read/write |
| 1 | any-edge | read/write |
| 2 | polarity | read/write |
| 3 | mask | read/write |
| 4 | raw status | read-only |
| 5 | masked status | read-only |
| 6 | clear | write-only |
| 7 | unused | read-only |

## Requirements
- R1: After synchronous reset, the sense, any-edge, polarity and mask registers (addresses 0 to 3) read 0, raw status (address 4) reads 0 and `irq_o` is 0.
- R2: A pin change reaches edge raw status on the third rising clock edge after the change, not on the second. This covers two synchronizer stages plus the detection register.
- R3: When sense is 0 (edge mode), any-edge is 0 and polarity is 1, a 0-to-1 transition sets the pin's raw status bit and a 1-to-0 transition does not.
- R4: When sense is 0, any-edge is 0 and polarity is 0, a 1-to-0 transition sets the raw bit and a 0-to-1 transition does not.
- R5: When sense is 0 and any-edge is 1, both transition directions set the raw bit, whatever the polarity bit holds.
- R6: When sense is 1 (level mode), the raw bit equals the synchronized pin if polarity is 1, and its inverse if polarity is 0. It is visible on the second rising edge after the pin changes and drops again when the pin leaves the active value.
- R7: An edge raw bit stays set until a write to address 6 with a 1 in that bit position. A 0 in that position leaves the bit set.
- R8: A write to address 6 has no effect on a raw bit whose pin is in level mode.
- R9: If an edge is detected in the same cycle as a clear write for that bit, the raw bit is left set.
- R10: Masked status (address 5) equals raw status AND mask (address 3), and `irq_o` is 1 exactly when masked status is nonzero.
- R11: Reads of address 6 and address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous input pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | NUM_PINS | Register write data, one bit per pin |
| reg_rdata | output | NUM_PINS | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Edge raw status is due on the third rising edge after a pin is driven, and level status is due on the second. Masked status and `irq_o` follow raw status in the same cycle. The bench drives pins on falling edges, counts the exact number of rising edges, and samples on the next falling edge. It also checks one edge earlier, to show that a result does not arrive too soon. Register writes take effect at the rising edge that ends the write cycle. For the clear-collision case, the clear write is placed on the very edge that registers the detected event.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SENSE = 3'd0,
        A_ANY   = 3'd1,
        A_POL   = 3'd2,
        A_MASK  = 3'd3,
        A_RAW   = 3'd4,
        A_MSTAT = 3'd5,
        A_CLR   = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

    // per-pin detection setup
    typedef struct packed {
        logic level;   // 1: level sense, 0: edge sense
        logic any;     // edge mode: both directions
        logic pol;     // 1: rising / high, 0: falling / low
    } pin_cfg_t;

    function automatic logic edge_hit(pin_cfg_t c, logic rise, logic fall);
        if (c.any) return rise | fall;
        return c.pol ? rise : fall;
    endfunction

    function automatic logic level_hit(pin_cfg_t c, logic s);
        return c.pol ? s : ~s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] sync_o
);
    logic [NUM_PINS-1:0] stage1_q;
    logic [NUM_PINS-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pin_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] sense_o,
    output logic [NUM_PINS-1:0] any_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] mask_o,
    output logic [NUM_PINS-1:0] clr_o
);
    logic [NUM_PINS-1:0] sense_q, any_q, pol_q, mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            any_q   <= '0;
            pol_q   <= '0;
            mask_q  <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                A_SENSE: sense_q <= wdata;
                A_ANY:   any_q   <= wdata;
                A_POL:   pol_q   <= wdata;
                A_MASK:  mask_q  <= wdata;
                default: ;
            endcase
        end
    end

    assign clr_o   = (we && reg_addr_e'(addr) == A_CLR) ? wdata : '0;
    assign sense_o = sense_q;
    assign any_o   = any_q;
    assign pol_o   = pol_q;
    assign mask_o  = mask_q;

    // R1: configuration is cleared by reset
    assert_cfg_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> (sense_q == '0 && any_q == '0 && pol_q == '0 && mask_q == '0));
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg_i,
    input  logic     sync_i,
    input  logic     clr_i,
    output logic     raw_o
);
    logic prev_q;
    logic latch_q;
    logic rise, fall, evt;

    assign rise = sync_i & ~prev_q;
    assign fall = ~sync_i & prev_q;
    assign evt  = edge_hit(cfg_i, rise, fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= sync_i;
            if (cfg_i.level)
                latch_q <= 1'b0;
            else
                latch_q <= (latch_q & ~clr_i) | evt;
        end
    end

    assign raw_o = cfg_i.level ? level_hit(cfg_i, sync_i) : latch_q;

    // R9: an edge that coincides with a clear is kept
    assert_clr_collision_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.level && evt && clr_i) |=> latch_q);

    // R7: a held edge survives while no clear bit is written
    assert_edge_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.level && latch_q && !clr_i) |=> latch_q);

    // R6: level mode never leaves a held edge behind
    assert_level_unlatched_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_i.level |=> !latch_q);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] sync_s;
    logic [NUM_PINS-1:0] sense_s, any_s, pol_s, mask_s, clr_s;
    logic [NUM_PINS-1:0] raw_s;
    logic [NUM_PINS-1:0] mstat_s;

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .sync_o (sync_s)
    );

    gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .sense_o (sense_s),
        .any_o   (any_s),
        .pol_o   (pol_s),
        .mask_o  (mask_s),
        .clr_o   (clr_s)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_cfg_t pcfg;
        assign pcfg = '{level: sense_s[i], any: any_s[i], pol: pol_s[i]};

        gpio_pin_detect u_det (
            .clk    (clk),
            .rst    (rst),
            .cfg_i  (pcfg),
            .sync_i (sync_s[i]),
            .clr_i  (clr_s[i]),
            .raw_o  (raw_s[i])
        );
    end

    assign mstat_s = raw_s & mask_s;
    assign irq_o   = |mstat_s;

    always_comb begin
        case (reg_addr_e'(reg_addr))
            A_SENSE: reg_rdata = sense_s;
            A_ANY:   reg_rdata = any_s;
            A_POL:   reg_rdata = pol_s;
            A_MASK:  reg_rdata = mask_s;
            A_RAW:   reg_rdata = raw_s;
            A_MSTAT: reg_rdata = mstat_s;
            default: reg_rdata = '0;
        endcase
    end

    // R10: a fully masked port never requests
    assert_mask_gates_R10: assert property (@(posedge clk) disable iff (rst)
        (mask_s == '0) |-> !irq_o);

    // R10: a request always has at least one unmasked raw source
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((raw_s & mask_s) != '0));
endmodule

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] pin_i;
    logic         reg_we;
    logic [2:0]   reg_addr;
    logic [N-1:0] reg_wdata;
    logic [N-1:0] reg_rdata;
    logic         irq_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_irq_detect #(.NUM_PINS(N)) u_gpio_irq_detect (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pin_i),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    // {level, any, pol, v0, v1, expected raw bit}
    localparam logic [5:0] VEC [11] = '{
        6'b001011,  // R3 rising caught
        6'b001100,  // R3 falling ignored
        6'b000101,  // R4 falling caught
        6'b000010,  // R4 rising ignored
        6'b010011,  // R5 any-edge rising, pol 0
        6'b011101,  // R5 any-edge falling, pol 1
        6'b010000,  // R5 no change
        6'b101011,  // R6 level high active
        6'b101100,  // R6 level high inactive
        6'b100101,  // R6 level low active
        6'b100010   // R6 level low inactive
    };

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog actual=0 expected=1");
        total++; bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] d;
        rst = 1'b1; pin_i = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check(d == '0, "R1 reset register", d, '0);
        end
        check(irq_o == 1'b0, "R1 reset irq", N'(irq_o), '0);

        // table walk over modes
        for (int k = 0; k < 11; k++) begin
            int p;
            logic [N-1:0] b;
            logic lv, an, po, v0, v1, ex;
            p = k % N;
            b = N'(1) << p;
            {lv, an, po, v0, v1, ex} = VEC[k];
            pin_i = '0;
            edges(4);
            wr(3'd0, lv ? b : '0);
            wr(3'd1, an ? b : '0);
            wr(3'd2, po ? b : '0);
            pin_i[p] = v0;
            edges(4);
            wr(3'd6, '1);
            pin_i[p] = v1;
            edges(3);
            rd(3'd4, d);
            check(d[p] == ex, $sformatf("R3-6 vector %0d raw", k), N'(d[p]), N'(ex));
        end

        // reset config to falling-edge default, pins low, cleared
        pin_i = '0;
        wr(3'd0, '0); wr(3'd1, '0); wr(3'd2, '0);
        edges(4);
        wr(3'd6, '1);

        // R2: latency of edge status, rising on pin 1
        wr(3'd2, 8'h02);
        pin_i[1] = 1'b1;
        edges(2);
        rd(3'd4, d);
        check(d[1] == 1'b0, "R2 edge not yet at two edges", d, 8'h00);
        edges(1);
        rd(3'd4, d);
        check(d[1] == 1'b1, "R2 edge at third edge", d, 8'h02);

        // R7: a write of 0 in that bit leaves it set; a write of 1 clears
        wr(3'd6, 8'hFD);
        rd(3'd4, d);
        check(d[1] == 1'b1, "R7 clear with zero bit keeps", d, 8'h02);
        wr(3'd6, 8'h02);
        rd(3'd4, d);
        check(d[1] == 1'b0, "R7 clear with one bit", d, 8'h00);

        // R10: masking
        pin_i[1] = 1'b0;
        edges(4);
        pin_i[1] = 1'b1;
        edges(3);
        check(irq_o == 1'b0, "R10 irq masked off", N'(irq_o), '0);
        rd(3'd5, d);
        check(d == '0, "R10 masked status zero", d, '0);
        wr(3'd3, 8'h02);
        check(irq_o == 1'b1, "R10 irq unmasked", N'(irq_o), 8'h01);
        rd(3'd5, d);
        check(d == 8'h02, "R10 masked status", d, 8'h02);
        wr(3'd3, 8'hFD);
        check(irq_o == 1'b0, "R10 other mask bits", N'(irq_o), '0);
        wr(3'd3, '0);
        wr(3'd6, '1);

        // R6/R8: level-high on pin 4, visible after two edges, clear ignored
        wr(3'd0, 8'h10); wr(3'd2, 8'h10);
        pin_i[4] = 1'b1;
        edges(2);
        rd(3'd4, d);
        check(d[4] == 1'b1, "R6 level at second edge", d, 8'h10);
        wr(3'd6, 8'h10);
        rd(3'd4, d);
        check(d[4] == 1'b1, "R8 clear ignored in level mode", d, 8'h10);
        pin_i[4] = 1'b0;
        edges(2);
        rd(3'd4, d);
        check(d[4] == 1'b0, "R6 level drops", d, 8'h00);
        wr(3'd0, '0); wr(3'd2, '0);
        edges(2);
        wr(3'd6, '1);

        // R9: rising on pin 3 registered on the same edge as its clear
        wr(3'd2, 8'h08);
        pin_i[3] = 1'b1;
        repeat (2) @(posedge clk);
        wr(3'd6, 8'h08);
        rd(3'd4, d);
        check(d[3] == 1'b1, "R9 edge beats clear", d, 8'h08);

        // R11: clear and unused addresses read zero
        rd(3'd6, d);
        check(d == '0, "R11 clear reads zero", d, '0);
        rd(3'd7, d);
        check(d == '0, "R11 unused reads zero", d, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule